// File: doc/BRIEF.md
# Nonvolatile Write Guard

This block is the control front end for an on-chip data EEPROM and program flash array. It holds the CPU-visible control register, the unlock key port and the write-completion interrupt registers. It sits between the CPU, an external serial programming port and the array. The array is reached through a plain start/done handshake. The block issues `arr_start` for one cycle together with the operation type, and treats an operation as in flight until the array pulses `arr_done`.

An internal write reaches the array only when every guard passes together. The write-enable bit must be set. The start bit must be written in the cycle right after a two-step key sequence. A data write must come after the power-up lockout window has ended, and a flash write needs the configuration write-inhibit bit to permit it. The configuration word can be changed only from the external port. Through that port a bit can only move toward protection, and only an erase command returns the word to the unprotected state. External array access is granted only while both code-protect bits are clear. Internal reads are always allowed.

There are two resets. `por_n` is the power-on reset, and it also restarts the lockout timer. `sys_rst_n` covers every other reset, brown-out included. All ports are plain control and status signals. There is no streaming interface and so no back-pressure: the CPU register port is a single-cycle strobe, and the array accepts each `arr_start` pulse without stalling.

Top module: `nvm_guard`

## Requirements
- R1: After power-on reset every readable register reads 0x00. The control register at address 0, the key port at address 1, the flag register at address 2 and the enable register at address 3 all read 0x00, and control register bits 6..4 always read 0.
- R2: Any reset clears the write-enable bit (control bit 2). A write attempt made while the stored write-enable bit is 0 does not start, even if the same write sets bit 2.
- R3: A write starts only when control bit 1 is written in the cycle immediately after a key-port write of 0xAA, and that 0xAA write came directly after a key-port write of 0x55. Any gap or any other write in between discards the sequence.
- R4: A data-memory write (control bit 7 = 0) never starts until LOCK_CYCLES clock cycles have passed since power-on reset.
- R5: A program-flash write (control bit 7 = 1) never starts while configuration bit 0 (write allow) is 0.
- R6: The configuration word {bit 2 flash protect, bit 1 data protect, bit 0 write allow} changes only through `ext_cfg_we`/`ext_erase`. A programming write can only clear bit 0 and set bits 2..1, and `ext_erase` restores 3'b001.
- R7: `ext_rd_grant` and `ext_wr_grant` follow their requests only while configuration bits 2 and 1 are both 0. Otherwise they are 0.
- R8: Internal reads (control bit 0) and internal data writes are unaffected by the code-protect bits.
- R9: On an accepted operation, `arr_start` pulses for one cycle after the control write, with `arr_write` and `arr_prog` valid. Control bit 1 (or bit 0 for a read) stays 1 until `arr_done`, then clears by itself.
- R10: A non-power-on reset during a write sets the error bit (control bit 3). Such a reset keeps bits 7 and 3, and power-on reset clears them.
- R11: Write completion sets flag bit 4. `irq` equals flag bit 4 AND enable bit 4, and software clears the flag by writing 0.
- R12: Control register layout: bit 7 memory select, bit 3 error, bit 2 write enable, bit 1 write start, bit 0 read start. The select bit is not changed while an operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | Any other reset, active low, synchronous |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | Register address (0 control, 1 key, 2 flag, 3 enable) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Write-complete interrupt |
| arr_start | output | 1 | One-cycle start pulse to the array |
| arr_write | output | 1 | Operation is a write |
| arr_prog | output | 1 | Operation targets program flash |
| arr_done | input | 1 | Array finished the operation |
| ext_cfg_we | input | 1 | External configuration program strobe |
| ext_cfg_wdata | input | 3 | External configuration value |
| ext_erase | input | 1 | External full erase command |
| ext_rd_req | input | 1 | External read request |
| ext_wr_req | input | 1 | External write request |
| ext_rd_grant | output | 1 | External read granted |
| ext_wr_grant | output | 1 | External write granted |

## Verification
Write attempts are made in several forms: inside the lockout window, with no key sequence, with a one-cycle gap after the key, with write enable stored as 0, and as a correct sequence. Each form fails on a different guard, so each one shows whether that guard works on its own. The flash path is tried with write allow cleared, then after an attempted re-enable over the programming port, then after erase. This separates the one-way rule from erase. A reset placed in the middle of a flash write shows that select and error are kept while write enable is cleared.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_KEY   = 2'd1;
  localparam logic [1:0] A_IFLAG = 2'd2;
  localparam logic [1:0] A_IEN   = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int B_SEL  = 7;
  localparam int B_ERR  = 3;
  localparam int B_WREN = 2;
  localparam int B_WR   = 1;
  localparam int B_RD   = 0;
  localparam int B_CPLT = 4;

  typedef struct packed {
    logic cp_prog;
    logic cp_data;
    logic wr_allow;
  } cfg_t;
endpackage

// File: rtl/nvg_lockout.sv
module nvg_lockout #(
  parameter int unsigned LOCK_CYCLES = 1440000
) (
  input  logic clk,
  input  logic por_n,
  output logic active
);
  localparam int unsigned CW = (LOCK_CYCLES < 1) ? 1 : $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign active = (cnt_q != CW'(LOCK_CYCLES));

  always_ff @(posedge clk) begin
    if (!por_n)      cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + CW'(1);
  end

  // R4: once the window has closed it stays closed until power-on reset
  a_r4_window_stays_closed: assert property (@(posedge clk) disable iff (!por_n)
    !active |=> !active);
endmodule

// File: rtl/nvg_unlock.sv
module nvg_unlock import nvg_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       is_key,
  input  logic [7:0] wdata,
  output logic       armed
);
  logic half_q;
  logic armed_q;

  assign armed = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= wr_en && is_key && (wdata == KEY_SECOND) && half_q;
      if (wr_en) half_q <= is_key && (wdata == KEY_FIRST);
    end
  end

  // R3: the start window is open for one cycle only
  a_r3_window_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> !armed);
endmodule

// File: rtl/nvg_cfg.sv
module nvg_cfg import nvg_pkg::*; #(
  parameter logic [2:0] CFG_INIT = 3'b001
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       prog_we,
  input  logic [2:0] prog_wdata,
  input  logic       erase,
  output cfg_t       cfg
);
  cfg_t cfg_q;
  cfg_t wd;

  assign wd  = cfg_t'(prog_wdata);
  assign cfg = cfg_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cfg_q <= cfg_t'(CFG_INIT);
    end else if (erase) begin
      cfg_q <= cfg_t'(3'b001);
    end else if (prog_we) begin
      cfg_q.wr_allow <= cfg_q.wr_allow & wd.wr_allow;
      cfg_q.cp_data  <= cfg_q.cp_data  | wd.cp_data;
      cfg_q.cp_prog  <= cfg_q.cp_prog  | wd.cp_prog;
    end
  end

  // R6: no change without the external port
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (!prog_we && !erase) |=> $stable(cfg_q));
  // R6: without erase the word only tightens
  a_r6_only_tightens: assert property (@(posedge clk) disable iff (!por_n)
    !erase |=> (!$rose(cfg_q.wr_allow) && !$fell(cfg_q.cp_data) && !$fell(cfg_q.cp_prog)));
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard import nvg_pkg::*; #(
  parameter int unsigned LOCK_CYCLES = 1440000,
  parameter logic [2:0]  CFG_INIT    = 3'b001
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       cpu_we,
  input  logic [1:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq,
  output logic       arr_start,
  output logic       arr_write,
  output logic       arr_prog,
  input  logic       arr_done,
  input  logic       ext_cfg_we,
  input  logic [2:0] ext_cfg_wdata,
  input  logic       ext_erase,
  input  logic       ext_rd_req,
  input  logic       ext_wr_req,
  output logic       ext_rd_grant,
  output logic       ext_wr_grant
);
  logic rst_any_n;
  logic lock_active;
  logic armed;
  cfg_t cfg;

  logic sel_q, err_q, wren_q, wr_q, rd_q;
  logic flag_q, ien_q;
  logic start_q, opw_q, opp_q;

  logic ctrl_we, iflag_we, ien_we, busy, path_ok, wr_go, rd_go, ext_open;

  assign rst_any_n = por_n & sys_rst_n;

  nvg_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .por_n(por_n), .active(lock_active));

  nvg_unlock u_unlock (
    .clk(clk), .rst_n(rst_any_n), .wr_en(cpu_we),
    .is_key(cpu_addr == A_KEY), .wdata(cpu_wdata), .armed(armed));

  nvg_cfg #(.CFG_INIT(CFG_INIT)) u_cfg (
    .clk(clk), .por_n(por_n), .prog_we(ext_cfg_we),
    .prog_wdata(ext_cfg_wdata), .erase(ext_erase), .cfg(cfg));

  assign ctrl_we  = cpu_we && (cpu_addr == A_CTRL);
  assign iflag_we = cpu_we && (cpu_addr == A_IFLAG);
  assign ien_we   = cpu_we && (cpu_addr == A_IEN);
  assign busy     = wr_q | rd_q;
  assign path_ok  = cpu_wdata[B_SEL] ? cfg.wr_allow : !lock_active;
  assign wr_go    = ctrl_we && cpu_wdata[B_WR] && !busy && armed && wren_q && path_ok;
  assign rd_go    = ctrl_we && cpu_wdata[B_RD] && !busy && !wr_go;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      sel_q <= 1'b0; err_q <= 1'b0; wren_q <= 1'b0; wr_q <= 1'b0; rd_q <= 1'b0;
      flag_q <= 1'b0; ien_q <= 1'b0; start_q <= 1'b0; opw_q <= 1'b0; opp_q <= 1'b0;
    end else if (!sys_rst_n) begin
      err_q   <= err_q | wr_q;
      wren_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      flag_q  <= 1'b0;
      ien_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_go | rd_go;
      if (ctrl_we) begin
        if (!busy) sel_q <= cpu_wdata[B_SEL];
        err_q  <= cpu_wdata[B_ERR];
        wren_q <= cpu_wdata[B_WREN];
      end
      if (iflag_we) flag_q <= cpu_wdata[B_CPLT];
      if (ien_we)   ien_q  <= cpu_wdata[B_CPLT];
      if (arr_done) begin
        wr_q <= 1'b0;
        rd_q <= 1'b0;
        if (wr_q) flag_q <= 1'b1;
      end
      if (wr_go) begin
        wr_q  <= 1'b1;
        opw_q <= 1'b1;
        opp_q <= cpu_wdata[B_SEL];
      end
      if (rd_go) begin
        rd_q  <= 1'b1;
        opw_q <= 1'b0;
        opp_q <= cpu_wdata[B_SEL];
      end
    end
  end

  always_comb begin
    cpu_rdata = 8'h00;
    case (cpu_addr)
      A_CTRL: begin
        cpu_rdata[B_SEL]  = sel_q;
        cpu_rdata[B_ERR]  = err_q;
        cpu_rdata[B_WREN] = wren_q;
        cpu_rdata[B_WR]   = wr_q;
        cpu_rdata[B_RD]   = rd_q;
      end
      A_IFLAG: cpu_rdata[B_CPLT] = flag_q;
      A_IEN:   cpu_rdata[B_CPLT] = ien_q;
      default: cpu_rdata = 8'h00;
    endcase
  end

  assign irq       = flag_q & ien_q;
  assign arr_start = start_q;
  assign arr_write = opw_q;
  assign arr_prog  = opp_q;

  assign ext_open     = !(cfg.cp_data || cfg.cp_prog);
  assign ext_rd_grant = ext_rd_req && ext_open;
  assign ext_wr_grant = ext_wr_req && ext_open;

  // R3 / R2: a write start follows an open key window with write enable held
  a_r3_start_needs_key: assert property (@(posedge clk) disable iff (!rst_any_n)
    (arr_start && arr_write) |-> $past(armed && wren_q));
  // R4: no data write while the lockout window is open
  a_r4_no_early_data_write: assert property (@(posedge clk) disable iff (!rst_any_n)
    (arr_start && arr_write && !arr_prog) |-> $past(!lock_active));
  // R5: flash writes need write allow
  a_r5_flash_inhibit: assert property (@(posedge clk) disable iff (!rst_any_n)
    (arr_start && arr_write && arr_prog) |-> $past(cfg.wr_allow));
  // R9: start bit holds until done, then clears
  a_r9_wr_holds: assert property (@(posedge clk) disable iff (!rst_any_n)
    (wr_q && !arr_done) |=> wr_q);
  a_r9_wr_clears: assert property (@(posedge clk) disable iff (!rst_any_n)
    (wr_q && arr_done) |=> !wr_q);
  // R11: completion raises the flag
  a_r11_flag_on_done: assert property (@(posedge clk) disable iff (!rst_any_n)
    (wr_q && arr_done) |=> flag_q);
  // R10: reset in the middle of a write leaves the error bit set
  a_r10_err_on_reset: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && wr_q) |=> err_q);
endmodule

// File: tb/tb_nvm_guard.sv
module tb_nvm_guard;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic irq, arr_start, arr_write, arr_prog;
  logic arr_done = 1'b0;
  logic ext_cfg_we = 1'b0, ext_erase = 1'b0, ext_rd_req = 1'b0, ext_wr_req = 1'b0;
  logic [2:0] ext_cfg_wdata = 3'b000;
  logic ext_rd_grant, ext_wr_grant;

  int checks = 0, fails = 0, starts = 0, busy_cnt = 0;
  bit cmp_on = 0, done_flag = 0;

  // reference model state
  bit m_sel, m_err, m_wren, m_wr, m_rd, m_flag, m_ien, m_start, m_opw, m_opp, m_half, m_armed;
  int m_cnt;
  logic [2:0] m_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_guard #(.LOCK_CYCLES(LOCK), .CFG_INIT(3'b001)) dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .arr_start(arr_start), .arr_write(arr_write), .arr_prog(arr_prog), .arr_done(arr_done),
    .ext_cfg_we(ext_cfg_we), .ext_cfg_wdata(ext_cfg_wdata), .ext_erase(ext_erase),
    .ext_rd_req(ext_rd_req), .ext_wr_req(ext_wr_req),
    .ext_rd_grant(ext_rd_grant), .ext_wr_grant(ext_wr_grant));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference, one update per rising edge
  always @(posedge clk) begin
    bit busy, go_w, go_r, ctrl, ok;
    logic [2:0] ncfg;
    if (!por_n) begin
      {m_sel, m_err, m_wren, m_wr, m_rd, m_flag, m_ien, m_start, m_opw, m_opp, m_half, m_armed} = '0;
      m_cnt = 0;
      m_cfg = 3'b001;
    end else begin
      ncfg = m_cfg;
      if (ext_erase) ncfg = 3'b001;
      else if (ext_cfg_we) ncfg = {m_cfg[2] | ext_cfg_wdata[2], m_cfg[1] | ext_cfg_wdata[1],
                                   m_cfg[0] & ext_cfg_wdata[0]};
      if (!sys_rst_n) begin
        m_err = m_err | m_wr;
        {m_wren, m_wr, m_rd, m_flag, m_ien, m_start, m_half, m_armed} = '0;
      end else begin
        busy = m_wr || m_rd;
        ctrl = cpu_we && cpu_addr == 2'd0;
        ok   = cpu_wdata[7] ? m_cfg[0] : (m_cnt >= LOCK);
        go_w = ctrl && cpu_wdata[1] && !busy && m_armed && m_wren && ok;
        go_r = ctrl && cpu_wdata[0] && !busy && !go_w;
        m_start = go_w || go_r;
        m_armed = cpu_we && cpu_addr == 2'd1 && cpu_wdata == 8'hAA && m_half;
        if (cpu_we) m_half = (cpu_addr == 2'd1) && (cpu_wdata == 8'h55);
        if (ctrl) begin
          if (!busy) m_sel = cpu_wdata[7];
          m_err = cpu_wdata[3];
          m_wren = cpu_wdata[2];
        end
        if (cpu_we && cpu_addr == 2'd2) m_flag = cpu_wdata[4];
        if (cpu_we && cpu_addr == 2'd3) m_ien = cpu_wdata[4];
        if (arr_done) begin
          if (m_wr) m_flag = 1;
          m_wr = 0;
          m_rd = 0;
        end
        if (go_w) begin m_wr = 1; m_opw = 1; m_opp = cpu_wdata[7]; end
        if (go_r) begin m_rd = 1; m_opw = 0; m_opp = cpu_wdata[7]; end
      end
      m_cfg = ncfg;
      if (m_cnt < LOCK) m_cnt++;
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    logic [7:0] exp_rd;
    bit open;
    if (arr_start) starts++;
    if (cmp_on) begin
      case (cpu_addr)
        2'd0: exp_rd = {m_sel, 3'b000, m_err, m_wren, m_wr, m_rd};
        2'd2: exp_rd = {3'b000, m_flag, 4'h0};
        2'd3: exp_rd = {3'b000, m_ien, 4'h0};
        default: exp_rd = 8'h00;
      endcase
      open = !(m_cfg[1] || m_cfg[2]);
      chk("R12 cpu_rdata", cpu_rdata, exp_rd);
      chk("R11 irq", irq, m_flag & m_ien);
      chk("R3 arr_start", arr_start, m_start);
      if (m_start) chk("R9 arr_write/arr_prog", {arr_write, arr_prog}, {m_opw, m_opp});
      chk("R7 ext grants", {ext_rd_grant, ext_wr_grant}, {ext_rd_req & open, ext_wr_req & open});
    end
  end

  // array responder: done three cycles after start
  always @(posedge clk) begin
    #2;
    arr_done = 1'b0;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) arr_done = 1'b1;
    end
    if (arr_start) busy_cnt = 3;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #2;
    cpu_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cpu_we = 1'b0; cpu_addr = a;
    #1 v = cpu_rdata;
    @(posedge clk); #2;
  endtask

  task automatic unlock_ctrl(input logic [7:0] d);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    wr(2'd0, d);
  endtask

  task automatic ext_prog(input logic [2:0] v);
    ext_cfg_we = 1'b1; ext_cfg_wdata = v;
    @(posedge clk); #2;
    ext_cfg_we = 1'b0;
  endtask

  task automatic ext_do_erase();
    ext_erase = 1'b1;
    @(posedge clk); #2;
    ext_erase = 1'b0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(posedge clk);
    #2 por_n = 1'b1;
    cmp_on = 1;
    @(posedge clk); #2;

    // R1: reset state
    rd(2'd0, v); chk("R1 ctrl after POR", v, 8'h00);
    rd(2'd1, v); chk("R1 key port reads", v, 8'h00);
    rd(2'd2, v); chk("R1 flag after POR", v, 8'h00);
    rd(2'd3, v); chk("R1 enable after POR", v, 8'h00);

    // R4: data write inside the lockout window
    wr(2'd0, 8'h04);
    s0 = starts;
    unlock_ctrl(8'h06);
    idle(2);
    chk("R4 no start in lockout", starts - s0, 0);
    rd(2'd0, v); chk("R4 ctrl after refused write", v, 8'h04);
    idle(LOCK + 5);

    // R3: no key sequence
    s0 = starts;
    wr(2'd0, 8'h06); idle(2);
    chk("R3 no key, no start", starts - s0, 0);
    // R3: one-cycle gap after the key
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); idle(1); wr(2'd0, 8'h06); idle(2);
    chk("R3 gap discards key", starts - s0, 0);
    // R3: interleaved write breaks the sequence
    wr(2'd1, 8'h55); wr(2'd3, 8'h00); wr(2'd1, 8'hAA); wr(2'd0, 8'h06); idle(2);
    chk("R3 interleaved write discards key", starts - s0, 0);
    // R2: stored write enable is 0
    wr(2'd0, 8'h00);
    unlock_ctrl(8'h06); idle(2);
    chk("R2 wren stored 0 blocks", starts - s0, 0);

    // R9 / R11: correct data write
    wr(2'd3, 8'h10);
    unlock_ctrl(8'h06);
    rd(2'd0, v); chk("R9 start bit held", v, 8'h06);
    idle(5);
    chk("R9 one start pulse", starts - s0, 1);
    rd(2'd0, v); chk("R9 start bit cleared on done", v, 8'h04);
    chk("R11 irq after completion", irq, 1);
    rd(2'd2, v); chk("R11 flag bit 4", v, 8'h10);
    wr(2'd2, 8'h00);
    chk("R11 irq cleared", irq, 0);

    // R7 / R8: data protect set
    ext_prog(3'b011);
    ext_rd_req = 1'b1; ext_wr_req = 1'b1;
    #1 chk("R7 ext blocked", {ext_rd_grant, ext_wr_grant}, 2'b00);
    s0 = starts;
    wr(2'd0, 8'h05); idle(5);
    chk("R8 internal read under protect", starts - s0, 1);
    unlock_ctrl(8'h06); idle(5);
    chk("R8 data write under protect", starts - s0, 2);
    ext_do_erase();
    #1 chk("R6 erase reopens ext", {ext_rd_grant, ext_wr_grant}, 2'b11);
    ext_rd_req = 1'b0; ext_wr_req = 1'b0;

    // R5 / R6: flash writes and write allow
    ext_prog(3'b000);
    s0 = starts;
    unlock_ctrl(8'h86); idle(2);
    chk("R5 flash write inhibited", starts - s0, 0);
    rd(2'd0, v); chk("R5 ctrl after refusal", v, 8'h84);
    ext_prog(3'b001);
    unlock_ctrl(8'h86); idle(2);
    chk("R6 re-enable without erase refused", starts - s0, 0);
    ext_do_erase();
    unlock_ctrl(8'h86); idle(5);
    chk("R6 flash write after erase", starts - s0, 1);

    // R10 / R2: reset in the middle of a flash write
    unlock_ctrl(8'h86);
    sys_rst_n = 1'b0;
    @(posedge clk); #2;
    sys_rst_n = 1'b1;
    rd(2'd0, v); chk("R10 err set, sel kept, R2 wren cleared", v, 8'h88);
    idle(6);
    por_n = 1'b0;
    @(posedge clk); #2;
    por_n = 1'b1;
    rd(2'd0, v); chk("R10 POR clears sel and err", v, 8'h00);
    idle(2);
    finish_up();
  end
endmodule